// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-interface master for external Ethernet PHYs. Software programs it through a small 32-bit register bus and the block runs one Clause 22 management frame per request. It derives the management clock (MDC) from the system clock with a programmable divider. It drives the shared bidirectional data line through separate output, output-enable and input pins, so the pad cell sits outside the block.

A transaction is started by writing the user-access word with its go bit set. The word carries the PHY address, the register address, the direction and, for writes, the payload. Go reads back as 1 for as long as the frame is on the wire and drops by itself when the frame ends, so software only has to poll one bit. After a read, the low half of the same word holds the returned value, and an acknowledge bit tells software whether a PHY actually drove the line during turnaround. Clearing the enable bit stops the controller, and a frame in flight is abandoned.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control word reads 0x800000FF, meaning idle=1, enable=0 and divider=0xFF. The user-access word reads 0. MDC and the output enable are both low.
- R2: While a frame runs, MDC has a period of max(divider,1)+1 system clocks. MDC stays low whenever no frame is running.
- R3: The control word sits at offset 0x04. Bit 30 is enable (read/write), bit 31 is idle (read-only, 1 exactly when no frame runs) and bits 15:0 hold the divider. The user-access word sits at offset 0x80. Every other offset reads 0.
- R4: The user-access word has these fields: go at bit 31, write at bit 30, acknowledge at bit 29, register address at 25:21, PHY address at 20:16 and data at 15:0. A write with go=1 while enabled and idle starts exactly one frame. Go reads 1 until that frame ends and then reads 0.
- R5: A frame is 64 MDC cycles long and is sent MSB first. It carries 32 ones, start 01, opcode (10 read, 01 write), the PHY address, the register address, 2 turnaround bits and 16 data bits.
- R6: In a write frame, the turnaround is driven as 10 and the data field is driven as payload. The output enable stays high for the whole frame. Afterwards acknowledge reads 1 and data reads back as written.
- R7: In a read frame, the output enable is low for the last 18 bits. Data is sampled on MDC rising edges into bits 15:0. Acknowledge is set when the line is sampled low in the second turnaround bit.
- R8: If no PHY pulls the line low in the second turnaround bit of a read, acknowledge reads 0.
- R9: The data output changes only together with a falling MDC edge. It is stable while MDC is high.
- R10: A go written while the controller is disabled starts nothing. Any user-access write made while a frame runs is ignored and leaves that frame unchanged.
- R11: Clearing enable during a frame aborts it. Idle reads 1, go reads 0, and MDC and the output enable return low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (functional) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Several rules are checked by assertions on every clock:
- MDC stays low outside frames, and it rises only on the divider's rising tick.
- The data output holds still while MDC is high.
- The output enable is off outside frames and on throughout write frames.
- The go bit always agrees with the sequencer's busy state.

Bit-exact frame content, the turnaround release, acknowledge and data capture, MDC periods across divider values, and the ignore and abort rules are shown only by the bench. Its behavioural PHY sweeps PHY and register addresses, payloads, and answered and unanswered reads.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DIV_W = 16;
  localparam logic [7:0] CTRL_OFS = 8'h04;
  localparam logic [7:0] USER_OFS = 8'h80;
  localparam logic [DIV_W-1:0] DIV_RESET = 16'h00FF;
  // bit indices inside a 64-bit frame, counted from the first bit sent
  localparam logic [5:0] TA1_IDX  = 6'd46;
  localparam logic [5:0] TA2_IDX  = 6'd47;
  localparam logic [5:0] DATA_IDX = 6'd48;
  localparam logic [5:0] LAST_IDX = 6'd63;

  // divider value actually used: zero is raised to one
  function automatic logic [DIV_W-1:0] mdc_span(input logic [DIV_W-1:0] div);
    return (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
  endfunction

  // number of system clocks MDC stays low in each period
  function automatic logic [DIV_W-1:0] mdc_low_len(input logic [DIV_W-1:0] div);
    logic [DIV_W:0] per;
    per = {1'b0, mdc_span(div)} + {{DIV_W{1'b0}}, 1'b1};
    return per[DIV_W:1];
  endfunction

  // complete frame image, first bit at [63]
  function automatic logic [63:0] frame_word(input logic wr, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] span;
  logic [DIV_W-1:0] low_len;

  assign span      = mdc_span(div);
  assign low_len   = mdc_low_len(div);
  assign rise_tick = run && (cnt == low_len - {{(DIV_W-1){1'b0}}, 1'b1});
  assign fall_tick = run && (cnt >= span);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_tick) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + {{(DIV_W-1){1'b0}}, 1'b1};
      if (rise_tick) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  input  logic        wr,
  input  logic [4:0]  phy,
  input  logic [4:0]  rg,
  input  logic [15:0] wdata,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [63:0] sh;
  logic [5:0]  idx;
  logic        wr_q;

  assign done    = busy && fall_tick && (idx == LAST_IDX);
  assign mdio_o  = busy ? sh[63] : 1'b1;
  assign mdio_oe = busy && (wr_q || (idx < TA1_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      sh    <= '0;
      wr_q  <= 1'b0;
      ack   <= 1'b0;
      rdata <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      sh   <= frame_word(wr, phy, rg, wdata);
      wr_q <= wr;
      ack  <= 1'b0;
    end else if (busy) begin
      if (rise_tick && !wr_q) begin
        if (idx == TA2_IDX) ack <= ~mdio_i;
        if (idx >= DATA_IDX) rdata <= {rdata[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          if (wr_q) ack <= 1'b1;
        end else begin
          sh  <= {sh[62:0], 1'b1};
          idx <= idx + 6'd1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             en;
  logic [DIV_W-1:0] div;
  logic             go_q;
  logic             u_wr;
  logic [4:0]       u_reg;
  logic [4:0]       u_phy;
  logic [15:0]      u_data;
  logic             busy, done, ack, start, abort;
  logic             rise_tick, fall_tick;
  logic [15:0]      rd_data;
  logic             ctrl_hit, user_hit;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata[29:16];
  assign ctrl_hit = reg_we && (reg_addr == CTRL_OFS);
  assign user_hit = reg_we && (reg_addr == USER_OFS);
  assign start    = user_hit && reg_wdata[31] && en && !busy;
  assign abort    = busy && ctrl_hit && !reg_wdata[30];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      div    <= DIV_RESET;
      go_q   <= 1'b0;
      u_wr   <= 1'b0;
      u_reg  <= '0;
      u_phy  <= '0;
      u_data <= '0;
    end else begin
      if (ctrl_hit) begin
        en  <= reg_wdata[30];
        div <= reg_wdata[DIV_W-1:0];
      end
      if (user_hit && !busy) begin
        u_wr   <= reg_wdata[30];
        u_reg  <= reg_wdata[25:21];
        u_phy  <= reg_wdata[20:16];
        u_data <= reg_wdata[15:0];
        go_q   <= start;
      end
      if (done) begin
        go_q <= 1'b0;
        if (!u_wr) u_data <= rd_data;
      end
      if (abort) go_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      CTRL_OFS: reg_rdata = {~busy, en, {(30-DIV_W){1'b0}}, div};
      USER_OFS: reg_rdata = {go_q, u_wr, ack, 3'b000, u_reg, u_phy, u_data};
      default:  reg_rdata = '0;
    endcase
  end

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame u_frm (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .wr(reg_wdata[30]), .phy(reg_wdata[20:16]), .rg(reg_wdata[25:21]),
    .wdata(reg_wdata[15:0]), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .busy(busy), .done(done), .ack(ack), .rdata(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic go,
  input logic wr,
  input logic rise_tick,
  input logic fall_tick
);
  // R2
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !mdc);

  // R2
  tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));

  // R9
  mdc_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(rise_tick));

  // R9
  mdio_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc && $past(mdc)) |-> $stable(mdio_o));

  // R4
  go_busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go == busy);

  // R6
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr) |-> mdio_oe);

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .go(go_q), .wr(u_wr), .rise_tick(rise_tick), .fall_tick(fall_tick)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // behavioural PHY: records every bit seen on MDC rise, answers from resp
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  logic [63:0] resp = '1;
  int rises = 0;
  int base = 0;
  int ridx;
  assign ridx = rises - base;
  assign mdio_i = (ridx >= 0 && ridx < 64) ? resp[63 - ridx] : 1'b1;

  always @(posedge mdc) begin
    cap_o  <= {cap_o[62:0], mdio_o};
    cap_oe <= {cap_oe[62:0], mdio_oe};
    rises  <= rises + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 40000; i++) begin
      rd_reg(8'h80, v);
      if (!v[31]) return;
    end
  endtask

  // one full transaction with checks on wire content and readback
  task automatic run_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] d, input logic answer, input logic [15:0] rv);
    logic [63:0] exp_bits, mask;
    logic [31:0] v;
    logic [15:0] exp_data;
    logic        exp_ack;
    resp = '1;
    if (answer) begin
      resp[16] = 1'b0;        // second turnaround bit (frame bit 47)
      resp[15:0] = rv;
    end
    base = rises;
    wr_reg(8'h80, {1'b1, wr, 1'b0, 3'b000, rg, phy, d});
    rd_reg(8'h80, v);
    check("R4 go high during frame", v[31], 1'b1);
    rd_reg(8'h04, v);
    check("R3 idle low during frame", v[31], 1'b0);
    wait_idle();
    check("R5 frame length in MDC cycles", rises - base, 64);
    exp_bits = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 2'b10, d};
    if (wr) exp_bits[29:28] = 2'b01;
    mask = wr ? 64'hFFFF_FFFF_FFFF_FFFF : ~64'h3_FFFF;
    check(wr ? "R6 output enable" : "R7 output enable", cap_oe, mask);
    check("R5 frame bits", cap_o & mask, exp_bits & mask);
    exp_ack  = wr ? 1'b1 : answer;
    exp_data = wr ? d : (answer ? rv : 16'hFFFF);
    rd_reg(8'h80, v);
    check(wr ? "R6 readback" : (answer ? "R7 readback" : "R8 readback"),
          v, {1'b0, wr, exp_ack, 3'b000, rg, phy, exp_data});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    realtime t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(8'h04, v);
    check("R1 control after reset", v, 32'h8000_00FF);
    rd_reg(8'h80, v);
    check("R1 user after reset", v, 32'h0);
    check("R1 mdc/oe after reset", {mdc, mdio_oe}, 2'b00);
    // R3 unmapped offset
    rd_reg(8'h08, v);
    check("R3 unmapped offset reads zero", v, 32'h0);

    // R10 go while disabled
    base = rises;
    wr_reg(8'h80, 32'hC000_1234);
    repeat (600) @(negedge clk);
    rd_reg(8'h80, v);
    check("R10 go ignored while disabled", v[31], 1'b0);
    check("R10 no MDC while disabled", rises - base, 0);

    // R3 enable with divider 1
    wr_reg(8'h04, 32'h4000_0001);
    rd_reg(8'h04, v);
    check("R3 control readback", v, 32'hC000_0001);

    // sweep over addresses, directions and payloads
    for (int p = 0; p < 32; p += 5) begin
      logic [15:0] pd;
      pd = 16'(p * 16'h0913) ^ 16'hA5C3;
      run_frame(1'b1, 5'(p), 5'(31 - p), pd, 1'b0, 16'h0);
      run_frame(1'b0, 5'(31 - p), 5'(p), 16'h0, (p % 10) == 0, ~pd);
    end
    run_frame(1'b0, 5'd31, 5'd31, 16'h0, 1'b1, 16'h0000);
    run_frame(1'b0, 5'd1, 5'd0, 16'h0, 1'b1, 16'hFFFF);
    run_frame(1'b1, 5'd31, 5'd0, 16'h8001, 1'b0, 16'h0);

    // R2 MDC period for several divider values
    for (int k = 0; k < 5; k++) begin
      logic [15:0] dv;
      int exp_per;
      dv = (k == 4) ? 16'd6 : 16'(k);
      exp_per = ((dv == 0) ? 1 : int'(dv)) + 1;
      wr_reg(8'h04, {16'h4000, dv});
      wr_reg(8'h80, 32'hC000_0000);
      @(posedge mdc); t1 = $realtime;
      @(posedge mdc); t2 = $realtime;
      check("R2 MDC period", int'((t2 - t1) / 20.0), exp_per);
      wait_idle();
      check("R2 MDC low when idle", mdc, 1'b0);
    end

    // R10 user write during a frame is ignored
    wr_reg(8'h04, 32'h4000_0001);
    resp = '1;
    base = rises;
    wr_reg(8'h80, {1'b1, 1'b1, 4'b0, 5'd3, 5'd7, 16'h5A5A});
    repeat (20) @(negedge clk);
    wr_reg(8'h80, {1'b1, 1'b0, 4'b0, 5'd9, 5'd2, 16'h1111});
    wait_idle();
    check("R10 busy write left frame intact", cap_o,
          {32'hFFFF_FFFF, 4'b0101, 5'd7, 5'd3, 2'b10, 16'h5A5A});
    rd_reg(8'h80, v);
    check("R10 busy write left fields intact", v,
          {3'b011, 3'b000, 5'd3, 5'd7, 16'h5A5A});

    // R11 abort by clearing enable
    wr_reg(8'h04, 32'h4000_0003);
    wr_reg(8'h80, {1'b1, 1'b0, 4'b0, 5'd4, 5'd4, 16'h0});
    repeat (100) @(negedge clk);
    wr_reg(8'h04, 32'h0000_0003);
    repeat (2) @(negedge clk);
    rd_reg(8'h04, v);
    check("R11 idle after abort", v, 32'h8000_0003);
    rd_reg(8'h80, v);
    check("R11 go and ack low after abort", v[31:29], 3'b000);
    check("R11 mdc/oe low after abort", {mdc, mdio_oe}, 2'b00);

    // recovery after abort
    wr_reg(8'h04, 32'h4000_0001);
    run_frame(1'b0, 5'd12, 5'd19, 16'h0, 1'b1, 16'hC3A5);

    summary();
  end
endmodule